// File: doc/BRIEF.md
# Capture/Reload 16-bit Timer-Counter

This peripheral keeps a 16-bit count that advances either on a prescaled internal tick or on falling edges of an external count pin. A byte-wide register bus configures it and gives access to the count and to a second 16-bit holding register. That register is a capture register in one mode and a reload register in the others. A separate trigger pin can latch the count or restart it from the reload value. Each count wrap raises an overflow flag and a one-cycle overflow pulse.

The block has four operating behaviours. In capture mode the count wraps to zero, and a trigger edge copies the count. In reload mode a wrap, or a trigger edge, loads the reload value. Up/down mode is a reload variant in which the trigger pin level sets the count direction. Baud mode is selected by either serial clock select bit. It forces reload on wrap, whatever the capture select says. In baud mode the overflow pulse is routed to the serial transmit or receive tick output. Both pins are synchronised with two flops before edge detection, so an input pulse must be high and then low for at least one clock each to be seen.

Top module: `cap_reload_timer`

## Requirements
- R1: After synchronous reset every register reads 0x00 and all outputs are 0.
- R2: With the run bit (control bit 2) at 0, the count holds. No tick and no count-pin edge changes it.
- R3: Control bit 1 selects the count source: 0 selects the `tick_in` input, and 1 selects falling edges of `cnt_pin`. A falling edge is a change of the synchronised pin from 1 to 0. While bit 1 is 1, `tick_in` has no effect.
- R4: In capture mode (control bit 0 = 1, bits 5 and 4 = 0) an up count from 0xFFFF gives 0x0000. Every wrap sets the overflow flag (control bit 7) and drives `ovf_pulse` high for the following cycle.
- R5: In capture mode with trigger enable (control bit 3) set, a falling trigger edge copies the current count into the holding register and sets the trigger flag (control bit 6). The count is unchanged by the edge.
- R6: With trigger enable at 0, trigger edges change neither the count, the holding register nor the trigger flag.
- R7: In reload mode (control bits 0, 5 and 4 all 0), a wrap loads the holding register value into the count. When trigger enable is set, a falling trigger edge also loads that value and sets the trigger flag.
- R8: If control bit 5 or bit 4 is set, the block is in baud mode and reloads on wrap, even if capture is selected. A trigger edge then neither captures nor reloads, but still sets the trigger flag when enabled.
- R9: `tx_baud_tick` equals `ovf_pulse` while control bit 4 is set, and `rx_baud_tick` equals `ovf_pulse` while control bit 5 is set. Otherwise each is 0.
- R10: Mode register bit 0 enables up/down counting in reload mode, when not in baud mode. In this mode a synchronised trigger level of 1 counts up and 0 counts down. Counting down from the holding value gives 0xFFFF and counts as a wrap. Trigger edges are ignored.
- R11: Register addresses are: control 0xC8, mode 0xC9, holding low byte 0xCA, holding high byte 0xCB, count low byte 0xCC, count high byte 0xCD. Mode bits 7..1 read 0, and unmapped addresses read 0x00.
- R12: A control write sets both flags to the written values. A hardware set of a flag in the same cycle takes priority over a written 0.
- R13: A bus write to a count byte replaces that byte, keeps the other byte, and suppresses counting and wrap for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Prescaled internal count enable |
| cnt_pin | input | 1 | Asynchronous external count input |
| trig_pin | input | 1 | Asynchronous external trigger / direction input |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ovf_flag | output | 1 | Overflow flag (control bit 7) |
| trig_flag | output | 1 | Trigger flag (control bit 6) |
| ovf_pulse | output | 1 | One-cycle pulse after each wrap |
| tx_baud_tick | output | 1 | Overflow pulse gated by the transmit clock select |
| rx_baud_tick | output | 1 | Overflow pulse gated by the receive clock select |

## Verification
The hardest situations to reach from the ports are the collisions within one clock: a wrap in the same cycle as a software write that clears the overflow flag, and a count byte write in the same cycle as a tick. The stimulus sets up the collision with a holding value of 0xFFFF, so that a running counter wraps on every tick, and keeps the tick high through the register write. The up/down wrap at the holding value is reached by loading a count just above it, with the trigger pin held low so that the synchronised direction is already down before counting starts.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int CNT_W       = 16;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_PINS    = 2;
    localparam int PIN_CNT     = 0;
    localparam int PIN_TRIG    = 1;

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'hC8;
    localparam logic [ADDR_W-1:0] A_MODE   = 8'hC9;
    localparam logic [ADDR_W-1:0] A_HOLD_L = 8'hCA;
    localparam logic [ADDR_W-1:0] A_HOLD_H = 8'hCB;
    localparam logic [ADDR_W-1:0] A_CNT_L  = 8'hCC;
    localparam logic [ADDR_W-1:0] A_CNT_H  = 8'hCD;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic ovf_f;
        logic trig_f;
        logic rx_sel;
        logic tx_sel;
        logic trig_en;
        logic run;
        logic ext_src;
        logic cap_sel;
    } ctrl_t;

    typedef struct packed {
        logic [BYTE_W-2:0] rsvd;
        logic              dn_en;
    } mode_t;

    typedef enum logic [1:0] {
        OP_CAPTURE,
        OP_RELOAD,
        OP_UPDOWN,
        OP_BAUD
    } op_mode_e;

    function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] v,
                                                  input logic hi,
                                                  input logic [BYTE_W-1:0] b);
        return hi ? {b, v[BYTE_W-1:0]} : {v[CNT_W-1:BYTE_W], b};
    endfunction

    function automatic op_mode_e decode_op(input ctrl_t c, input logic dn);
        if (c.rx_sel || c.tx_sel) return OP_BAUD;
        if (c.cap_sel)            return OP_CAPTURE;
        if (dn)                   return OP_UPDOWN;
        return OP_RELOAD;
    endfunction
endpackage

// File: rtl/crt_pin_sync.sv
module crt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_o <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin_i};
            prev_o <= sh_q[STAGES-1];
        end
    end

    assign level_o = sh_q[STAGES-1];
endmodule

// File: rtl/crt_core.sv
module crt_core
    import crt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              cnt_lvl_i,
    input  logic              cnt_prev_i,
    input  logic              trig_lvl_i,
    input  logic              trig_prev_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_mode_i,
    input  logic              wr_hold_l_i,
    input  logic              wr_hold_h_i,
    input  logic              wr_cnt_l_i,
    input  logic              wr_cnt_h_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output mode_t             mode_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  hold_o,
    output logic              ovf_pulse_o
);
    ctrl_t            ctrl_q, ctrl_n;
    mode_t            mode_q, mode_n;
    logic [CNT_W-1:0] cnt_q, cnt_n, hold_q, hold_n;
    op_mode_e         op;
    logic cnt_fall, trig_fall, step, count_up, trig_ev, trig_rld, cnt_wr, hold_wr, wrap;

    assign op        = decode_op(ctrl_q, mode_q.dn_en);
    assign cnt_fall  = cnt_prev_i & ~cnt_lvl_i;
    assign trig_fall = trig_prev_i & ~trig_lvl_i;

    always_comb begin
        step     = ctrl_q.run & (ctrl_q.ext_src ? cnt_fall : tick_i);
        count_up = (op != OP_UPDOWN) | trig_lvl_i;
        trig_ev  = ctrl_q.trig_en & trig_fall & (op != OP_UPDOWN);
        trig_rld = trig_ev & (op == OP_RELOAD);
        cnt_wr   = wr_cnt_l_i | wr_cnt_h_i;
        hold_wr  = wr_hold_l_i | wr_hold_h_i;

        wrap  = 1'b0;
        cnt_n = cnt_q;
        if (step) begin
            if (count_up) begin
                if (cnt_q == CNT_MAX) begin
                    wrap  = 1'b1;
                    cnt_n = (op == OP_CAPTURE) ? '0 : hold_q;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == hold_q) begin
                    wrap  = 1'b1;
                    cnt_n = CNT_MAX;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
        end
        if (trig_rld) cnt_n = hold_q;
        if (cnt_wr) begin
            wrap  = 1'b0;
            cnt_n = put_byte(cnt_q, wr_cnt_h_i, wdata_i);
        end

        hold_n = hold_q;
        if (hold_wr)
            hold_n = put_byte(hold_q, wr_hold_h_i, wdata_i);
        else if (trig_ev && op == OP_CAPTURE)
            hold_n = cnt_q;

        ctrl_n = wr_ctrl_i ? ctrl_t'(wdata_i) : ctrl_q;
        ctrl_n.ovf_f  = ctrl_n.ovf_f | wrap;
        ctrl_n.trig_f = ctrl_n.trig_f | trig_ev;

        mode_n = mode_q;
        if (wr_mode_i) mode_n.dn_en = wdata_i[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            mode_q      <= '0;
            cnt_q       <= '0;
            hold_q      <= '0;
            ovf_pulse_o <= 1'b0;
        end else begin
            ctrl_q      <= ctrl_n;
            mode_q      <= mode_n;
            cnt_q       <= cnt_n;
            hold_q      <= hold_n;
            ovf_pulse_o <= wrap;
        end
    end

    assign ctrl_o = ctrl_q;
    assign mode_o = mode_q;
    assign cnt_o  = cnt_q;
    assign hold_o = hold_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !cnt_wr && !trig_rld) |=> (cnt_q == $past(cnt_q)));

    assert_flag_with_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse_o |-> ctrl_q.ovf_f);

    assert_capture_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (trig_fall && ctrl_q.trig_en && op == OP_CAPTURE && !hold_wr) |=> (hold_q == $past(cnt_q)));

    assert_trig_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.trig_en && !wr_ctrl_i) |=> (ctrl_q.trig_f == $past(ctrl_q.trig_f)));

    assert_baud_no_trig_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BAUD && trig_fall && !step && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

    assert_up_step_R10: assert property (@(posedge clk) disable iff (rst)
        (op != OP_UPDOWN && step && !cnt_wr && !trig_rld && cnt_q != CNT_MAX)
            |=> (cnt_q == $past(cnt_q) + 16'd1));
endmodule

// File: rtl/crt_rd_mux.sv
module crt_rd_mux
    import crt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  ctrl_t             ctrl_i,
    input  mode_t             mode_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  hold_i,
    output logic [BYTE_W-1:0] rdata_o
);
    always_comb begin
        case (addr_i)
            A_CTRL:   rdata_o = ctrl_i;
            A_MODE:   rdata_o = mode_i;
            A_HOLD_L: rdata_o = hold_i[BYTE_W-1:0];
            A_HOLD_H: rdata_o = hold_i[CNT_W-1:BYTE_W];
            A_CNT_L:  rdata_o = cnt_i[BYTE_W-1:0];
            A_CNT_H:  rdata_o = cnt_i[CNT_W-1:BYTE_W];
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import crt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_in,
    input  logic        cnt_pin,
    input  logic        trig_pin,
    input  logic [7:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_we,
    output logic [7:0]  bus_rdata,
    output logic        ovf_flag,
    output logic        trig_flag,
    output logic        ovf_pulse,
    output logic        tx_baud_tick,
    output logic        rx_baud_tick
);
    logic [NUM_PINS-1:0] pin_raw, pin_lvl, pin_prev;
    ctrl_t               ctrl;
    mode_t               mode;
    logic [CNT_W-1:0]    cnt, hold;

    assign pin_raw[PIN_CNT]  = cnt_pin;
    assign pin_raw[PIN_TRIG] = trig_pin;

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_sync
        crt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst     (rst),
            .pin_i   (pin_raw[gi]),
            .level_o (pin_lvl[gi]),
            .prev_o  (pin_prev[gi])
        );
    end

    crt_core u_core (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_in),
        .cnt_lvl_i   (pin_lvl[PIN_CNT]),
        .cnt_prev_i  (pin_prev[PIN_CNT]),
        .trig_lvl_i  (pin_lvl[PIN_TRIG]),
        .trig_prev_i (pin_prev[PIN_TRIG]),
        .wr_ctrl_i   (bus_we && bus_addr == A_CTRL),
        .wr_mode_i   (bus_we && bus_addr == A_MODE),
        .wr_hold_l_i (bus_we && bus_addr == A_HOLD_L),
        .wr_hold_h_i (bus_we && bus_addr == A_HOLD_H),
        .wr_cnt_l_i  (bus_we && bus_addr == A_CNT_L),
        .wr_cnt_h_i  (bus_we && bus_addr == A_CNT_H),
        .wdata_i     (bus_wdata),
        .ctrl_o      (ctrl),
        .mode_o      (mode),
        .cnt_o       (cnt),
        .hold_o      (hold),
        .ovf_pulse_o (ovf_pulse)
    );

    crt_rd_mux u_rd (
        .addr_i  (bus_addr),
        .ctrl_i  (ctrl),
        .mode_i  (mode),
        .cnt_i   (cnt),
        .hold_i  (hold),
        .rdata_o (bus_rdata)
    );

    assign ovf_flag     = ctrl.ovf_f;
    assign trig_flag    = ctrl.trig_f;
    assign tx_baud_tick = ovf_pulse & ctrl.tx_sel;
    assign rx_baud_tick = ovf_pulse & ctrl.rx_sel;
endmodule

// File: tb/tb_cap_reload_timer.sv
module tb_cap_reload_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_in = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ovf_flag, trig_flag, ovf_pulse, tx_baud_tick, rx_baud_tick;

    int checks = 0;
    int bad = 0;
    bit cmp_on = 1'b0;

    always #2ns clk = ~clk;

    cap_reload_timer dut (
        .clk(clk), .rst(rst), .tick_in(tick_in), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .ovf_flag(ovf_flag), .trig_flag(trig_flag), .ovf_pulse(ovf_pulse),
        .tx_baud_tick(tx_baud_tick), .rx_baud_tick(rx_baud_tick)
    );

    // behavioural reference state
    logic [15:0] m_cnt = 0, m_hold = 0;
    logic [7:0]  m_ctrl = 0;
    logic        m_dn = 0, m_pulse = 0;
    logic [2:0]  m_cpin = 0, m_tpin = 0;   // [0] first sync, [1] second sync, [2] previous

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_hold = 0; m_ctrl = 0; m_dn = 0; m_pulse = 0; m_cpin = 0; m_tpin = 0;
        end else begin
            bit cfall, tfall, baud, capm, ud, stp, up, tev, ovf, cw, hw;
            logic [15:0] nc, nh;
            logic [7:0] nctl;
            cfall = m_cpin[2] && !m_cpin[1];
            tfall = m_tpin[2] && !m_tpin[1];
            baud  = m_ctrl[5] || m_ctrl[4];
            capm  = m_ctrl[0] && !baud;
            ud    = m_dn && !m_ctrl[0] && !baud;
            stp   = m_ctrl[2] && (m_ctrl[1] ? cfall : tick_in);
            up    = !ud || m_tpin[1];
            tev   = m_ctrl[3] && tfall && !ud;
            cw    = bus_we && (bus_addr == 8'hCC || bus_addr == 8'hCD);
            hw    = bus_we && (bus_addr == 8'hCA || bus_addr == 8'hCB);
            ovf = 0; nc = m_cnt;
            if (stp) begin
                if (up) begin
                    if (m_cnt == 16'hFFFF) begin ovf = 1; nc = capm ? 16'h0 : m_hold; end
                    else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == m_hold) begin ovf = 1; nc = 16'hFFFF; end
                    else nc = m_cnt - 1;
                end
            end
            if (tev && !capm && !baud) nc = m_hold;
            if (cw) begin
                ovf = 0;
                nc = (bus_addr == 8'hCD) ? {bus_wdata, m_cnt[7:0]} : {m_cnt[15:8], bus_wdata};
            end
            nh = m_hold;
            if (hw) nh = (bus_addr == 8'hCB) ? {bus_wdata, m_hold[7:0]} : {m_hold[15:8], bus_wdata};
            else if (tev && capm) nh = m_cnt;
            nctl = (bus_we && bus_addr == 8'hC8) ? bus_wdata : m_ctrl;
            nctl[7] = nctl[7] | ovf;
            nctl[6] = nctl[6] | tev;
            if (bus_we && bus_addr == 8'hC9) m_dn = bus_wdata[0];
            m_cnt = nc; m_hold = nh; m_ctrl = nctl; m_pulse = ovf;
            m_cpin = {m_cpin[1], m_cpin[0], cnt_pin};
            m_tpin = {m_tpin[1], m_tpin[0], trig_pin};
        end
    end

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'hC8: return m_ctrl;
            8'hC9: return {7'b0, m_dn};
            8'hCA: return m_hold[7:0];
            8'hCB: return m_hold[15:8];
            8'hCC: return m_cnt[7:0];
            8'hCD: return m_cnt[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R4",  "ovf_flag",     ovf_flag,     m_ctrl[7]);
            chk("R5",  "trig_flag",    trig_flag,    m_ctrl[6]);
            chk("R4",  "ovf_pulse",    ovf_pulse,    m_pulse);
            chk("R9",  "tx_baud_tick", tx_baud_tick, m_pulse && m_ctrl[4]);
            chk("R9",  "rx_baud_tick", rx_baud_tick, m_pulse && m_ctrl[5]);
            chk("R11", "bus_rdata",    bus_rdata,    m_read(bus_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); #1ns;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); #1ns;
        bus_we = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); #1ns;
        bus_addr = a;
        @(negedge clk);
        chk(req, "read", bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1ns;
    endtask

    task automatic trig_pulse();
        trig_pin = 1'b1; idle(4);
        trig_pin = 1'b0; idle(4);
    endtask

    task automatic run_all();
        idle(5);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1: reset values
        for (int a = 8'hC8; a <= 8'hCD; a++) rd_expect(8'(a), 8'h00, "R1");
        chk("R1", "outputs", {ovf_flag, trig_flag, ovf_pulse, tx_baud_tick, rx_baud_tick}, 0);
        // R11: reserved mode bits and unmapped address
        wr(8'hC9, 8'hFF);
        rd_expect(8'hC9, 8'h01, "R11");
        rd_expect(8'h00, 8'h00, "R11");
        wr(8'hC9, 8'h00);
        // R2: stopped counter holds through ticks
        wr(8'hCC, 8'h34); wr(8'hCD, 8'h12);
        tick_in = 1'b1; idle(5); tick_in = 1'b0;
        rd_expect(8'hCC, 8'h34, "R2");
        rd_expect(8'hCD, 8'h12, "R2");
        // R5: capture with trigger enabled, counter stopped
        wr(8'hC8, 8'h09);
        wr(8'hCC, 8'hCD); wr(8'hCD, 8'hAB);
        trig_pulse();
        rd_expect(8'hCA, 8'hCD, "R5");
        rd_expect(8'hCB, 8'hAB, "R5");
        rd_expect(8'hC8, 8'h49, "R5");
        // R12: flag cleared by writing 0
        wr(8'hC8, 8'h09);
        rd_expect(8'hC8, 8'h09, "R12");
        // R6: trigger disabled
        wr(8'hC8, 8'h01);
        wr(8'hCC, 8'h11); wr(8'hCD, 8'h11);
        trig_pulse();
        rd_expect(8'hCA, 8'hCD, "R6");
        rd_expect(8'hCC, 8'h11, "R6");
        rd_expect(8'hC8, 8'h01, "R6");
        // R7: trigger reload in reload mode
        wr(8'hC8, 8'h08);
        wr(8'hCA, 8'h78); wr(8'hCB, 8'h56);
        trig_pulse();
        rd_expect(8'hCC, 8'h78, "R7");
        rd_expect(8'hCD, 8'h56, "R7");
        rd_expect(8'hC8, 8'h48, "R7");
        // R7: wrap reload while running
        wr(8'hC8, 8'h00);
        wr(8'hCA, 8'hF0); wr(8'hCB, 8'hFF);
        wr(8'hCC, 8'hFE); wr(8'hCD, 8'hFF);
        wr(8'hC8, 8'h0C);
        tick_in = 1'b1; idle(6); trig_pulse(); tick_in = 1'b0;
        // R4: wrap to zero in capture mode, exactly four ticks
        wr(8'hC8, 8'h01);
        wr(8'hCC, 8'hFD); wr(8'hCD, 8'hFF);
        wr(8'hC8, 8'h05);
        tick_in = 1'b1; idle(4); tick_in = 1'b0;
        rd_expect(8'hCC, 8'h01, "R4");
        rd_expect(8'hCD, 8'h00, "R4");
        rd_expect(8'hC8, 8'h85, "R4");
        // R3: external count source, tick ignored
        wr(8'hC8, 8'h01);
        wr(8'hCC, 8'h00); wr(8'hCD, 8'h00);
        wr(8'hC8, 8'h07);
        tick_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cnt_pin = 1'b1; idle(4);
            cnt_pin = 1'b0; idle(4);
        end
        tick_in = 1'b0;
        rd_expect(8'hCC, 8'h03, "R3");
        rd_expect(8'hCD, 8'h00, "R3");
        // R8/R9: baud mode with transmit select overrides capture select
        wr(8'hC8, 8'h01);
        wr(8'hCA, 8'hFC); wr(8'hCB, 8'hFF);
        wr(8'hCC, 8'hFE); wr(8'hCD, 8'hFF);
        wr(8'hC8, 8'h1D);
        tick_in = 1'b1; idle(4); trig_pulse(); idle(4); tick_in = 1'b0;
        rd_expect(8'hCA, 8'hFC, "R8");
        chk("R8", "trig_flag", trig_flag, 1'b1);
        // R9: receive select
        wr(8'hC8, 8'h24);
        tick_in = 1'b1; idle(10); tick_in = 1'b0;
        rd_expect(8'hCB, 8'hFF, "R9");
        // R10: up/down
        wr(8'hC8, 8'h00);
        wr(8'hC9, 8'h01);
        wr(8'hCA, 8'h10); wr(8'hCB, 8'h00);
        wr(8'hCC, 8'h12); wr(8'hCD, 8'h00);
        wr(8'hC8, 8'h04);
        tick_in = 1'b1; idle(5); tick_in = 1'b0;
        rd_expect(8'hCC, 8'hFD, "R10");
        rd_expect(8'hCD, 8'hFF, "R10");
        trig_pin = 1'b1; idle(4);
        tick_in = 1'b1; idle(3); tick_in = 1'b0;
        rd_expect(8'hCC, 8'h10, "R10");
        rd_expect(8'hCD, 8'h00, "R10");
        trig_pin = 1'b0; idle(4);
        wr(8'hC9, 8'h00);
        // R12: hardware set beats a written 0 in the same cycle
        wr(8'hC8, 8'h00);
        wr(8'hCA, 8'hFF); wr(8'hCB, 8'hFF);
        wr(8'hCC, 8'hFF); wr(8'hCD, 8'hFF);
        wr(8'hC8, 8'h04);
        tick_in = 1'b1; idle(2);
        wr(8'hC8, 8'h04);
        rd_expect(8'hC8, 8'h84, "R12");
        tick_in = 1'b0;
        // R13: count byte write suppresses the tick of that cycle
        wr(8'hC8, 8'h01);
        wr(8'hCC, 8'h00); wr(8'hCD, 8'h7A);
        wr(8'hC8, 8'h05);
        tick_in = 1'b1; idle(3);
        wr(8'hCC, 8'h20);
        tick_in = 1'b0;
        rd_expect(8'hCC, 8'h20, "R13");
        rd_expect(8'hCD, 8'h7A, "R13");
        idle(4);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                bad++; checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule